// File: doc/BRIEF.md
# Slot-Table Time-Division Mesh Router

This block is a five-port mesh router that carries two traffic classes over the same links. Guaranteed-service (GS) flits are switched by a time-division schedule. A free-running counter cuts time into equal slots that repeat in rounds. Every router in the mesh leaves reset together, so the slot counters stay in lockstep. For each slot, a programmable table names the input that drives each output. A correct schedule never makes a GS flit wait, so each input holds GS traffic in one flit register and needs no queue.

Best-effort (BE) flits take a separate path. Each input has a four-flit queue. The head flit of each queue is routed by dimension order (X first, then Y) from the destination coordinates it carries. It may leave only on an output that the table leaves unreserved in the current slot. BE flits are single-flit packets, and each input queue sends its flits in arrival order.

The table has two copies. Writes through the configuration port go to a shadow copy. The whole shadow copy moves into the active copy when the slot counter wraps, so the schedule never changes in the middle of a round.

Top module: `tdm_router`

## Requirements
- R1: `cur_slot` is 0 after reset. It advances by one every SLOT_LEN (default 4) cycles, and after slot SLOTS-1 (default 7) it returns to 0.
- R2: A table entry holds 4 bits per output o, at bits [4o+3:4o]. Bit 4o+3 is the reserve flag and bits [4o+2:4o] select the input. A GS flit presented on an input in cycle c appears in cycle c+1 on every output whose entry for the slot of cycle c+1 is reserved and selects that input. It appears there with `out_gs`=1 and the same data.
- R3: A GS flit whose input is not selected by any reserved output in the slot of cycle c+1 appears on no output.
- R4: A reserved output never carries a BE flit, even when no GS flit is present for it. This includes an output whose select value is 5 or more.
- R5: A BE flit carries its destination X in data bits [15:14] and its destination Y in bits [13:12]; the router sits at (1,1). The flit goes to output 2 if X>1, to output 4 if X<1, and otherwise to output 1 if Y>1, to output 3 if Y<1, and to output 0 if the coordinates match. It appears with `out_gs`=0 in the cycle after it is accepted, provided that output is unreserved in that cycle.
- R6: When the head flits of several inputs want the same free output, the lowest-numbered input is sent first.
- R7: Each BE input queue holds 4 flits. `be_in_ready` is low while the queue is full, a fifth flit offered then is not taken, and the flits leave in the order they were accepted.
- R8: A BE flit leaves its queue only in a cycle in which its output's `out_ready` is high. Until then it is held. GS output does not depend on `out_ready`.
- R9: A table write changes the schedule only from the first slot after the next wrap of the slot counter.
- R10: During reset all `out_valid` bits are 0, all `be_in_ready` bits are 1 and `cur_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 3 | Slot number of the entry being written |
| cfg_entry | input | 20 | Entry value: 4 bits per output |
| gs_in_valid | input | 5 | GS flit present, one bit per input |
| gs_in_data | input | 5x16 | GS flit data, one word per input |
| be_in_valid | input | 5 | BE flit offered, one bit per input |
| be_in_ready | output | 5 | BE queue has room, one bit per input |
| be_in_data | input | 5x16 | BE flit data, one word per input |
| out_valid | output | 5 | Output carries a flit, one bit per output |
| out_gs | output | 5 | Flit on the output is GS |
| out_data | output | 5x16 | Output flit data |
| out_ready | input | 5 | Downstream can take a BE flit |
| cur_slot | output | 3 | Current slot number |

## Verification
A GS flit is due on its output exactly one cycle after it is presented. It is switched by the entry of the slot that is current in that following cycle. A BE flit is due one cycle after its acceptance edge, if its output is free then, and it is removed at the first edge on which that output's `out_ready` is high. A write to the table is due only after the following wrap. The bench drives inputs at the falling edge and samples at the next falling edge. It counts rising edges since reset release to predict the slot at each sample, and it places every stimulus in the cycle just before the slot it targets.

// File: rtl/tdm_router_pkg.sv
package tdm_router_pkg;

  localparam int ENTRY_W = 4;
  localparam int SEL_W   = 3;

  localparam int PORT_LOCAL = 0;
  localparam int PORT_NORTH = 1;
  localparam int PORT_EAST  = 2;
  localparam int PORT_SOUTH = 3;
  localparam int PORT_WEST  = 4;

  // Dimension-order choice: correct X first, then Y, then deliver locally.
  function automatic int xy_route(input int dst_x, input int dst_y,
                                  input int here_x, input int here_y);
    if (dst_x > here_x)      return PORT_EAST;
    else if (dst_x < here_x) return PORT_WEST;
    else if (dst_y > here_y) return PORT_NORTH;
    else if (dst_y < here_y) return PORT_SOUTH;
    else                     return PORT_LOCAL;
  endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter  int SLOTS    = 8,
  parameter  int SLOT_LEN = 4,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CW = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot_idx,
  output logic          round_end
);

  logic [CW-1:0] cyc_q, cyc_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          slot_end;

  always_comb begin
    slot_end  = (cyc_q == CW'(SLOT_LEN - 1));
    round_end = slot_end && (slot_q == SW'(SLOTS - 1));
    cyc_d     = slot_end ? '0 : cyc_q + 1'b1;
    slot_d    = slot_q;
    if (slot_end) slot_d = round_end ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      slot_q <= slot_d;
    end
  end

  assign slot_idx = slot_q;

  assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SW'(SLOTS - 1) && cyc_q == CW'(SLOT_LEN - 1)) |=> (slot_q == '0));

  assert_slot_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != CW'(SLOT_LEN - 1)) |=> $stable(slot_q));

endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
  parameter  int SLOTS = 8,
  parameter  int NP    = 5,
  parameter  int EW    = NP * 4,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_addr,
  input  logic [EW-1:0] cfg_entry,
  input  logic          round_end,
  input  logic [SW-1:0] slot_idx,
  output logic [EW-1:0] cur_entry
);

  logic [SLOTS-1:0][EW-1:0] shadow_q, shadow_d;
  logic [SLOTS-1:0][EW-1:0] active_q, active_d;

  always_comb begin
    shadow_d = shadow_q;
    for (int s = 0; s < SLOTS; s++) begin
      if (cfg_we && (cfg_addr == SW'(s))) shadow_d[s] = cfg_entry;
    end
    // The copy takes the shadow as it stood before this cycle's write.
    active_d = round_end ? shadow_q : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  always_comb begin
    cur_entry = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_idx == SW'(s)) cur_entry = active_q[s];
    end
  end

  assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !round_end |=> $stable(active_q));

endmodule

// File: rtl/tdm_be_fifo.sv
module tdm_be_fifo #(
  parameter  int W     = 16,
  parameter  int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         head_valid,
  output logic [W-1:0] head_data,
  input  logic         pop
);

  logic [DEPTH-1:0][W-1:0] mem_q, mem_d;
  logic [AW-1:0]           wr_q, wr_d, rd_q, rd_d;
  logic [NW-1:0]           cnt_q, cnt_d;
  logic                    push, take;

  always_comb begin
    in_ready   = (cnt_q != NW'(DEPTH));
    head_valid = (cnt_q != '0);
    head_data  = mem_q[rd_q];
    push       = in_valid && in_ready;
    take       = pop && head_valid;
    mem_d      = mem_q;
    wr_d       = wr_q;
    rd_d       = rd_q;
    if (push) begin
      mem_d[wr_q] = in_data;
      wr_d        = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
    if (take) rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    cnt_d = cnt_q + NW'(push) - NW'(take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/tdm_router.sv
module tdm_router
  import tdm_router_pkg::*;
#(
  parameter  int NP       = 5,
  parameter  int W        = 16,
  parameter  int SLOTS    = 8,
  parameter  int SLOT_LEN = 4,
  parameter  int BE_DEPTH = 4,
  parameter  int COORD_W  = 2,
  parameter  int MY_X     = 1,
  parameter  int MY_Y     = 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int EW = NP * ENTRY_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [SW-1:0]          cfg_addr,
  input  logic [EW-1:0]          cfg_entry,
  input  logic [NP-1:0]          gs_in_valid,
  input  logic [NP-1:0][W-1:0]   gs_in_data,
  input  logic [NP-1:0]          be_in_valid,
  output logic [NP-1:0]          be_in_ready,
  input  logic [NP-1:0][W-1:0]   be_in_data,
  output logic [NP-1:0]          out_valid,
  output logic [NP-1:0]          out_gs,
  output logic [NP-1:0][W-1:0]   out_data,
  input  logic [NP-1:0]          out_ready,
  output logic [SW-1:0]          cur_slot
);

  logic                         round_end;
  logic [EW-1:0]                cur_entry;
  logic [NP-1:0]                gs_vld_q, gs_vld_d;
  logic [NP-1:0][W-1:0]         gs_dat_q, gs_dat_d;
  logic [NP-1:0]                be_head_vld, be_pop;
  logic [NP-1:0][W-1:0]         be_head;
  logic [NP-1:0][SEL_W-1:0]     be_route;
  logic [NP-1:0]                reserved, gs_hit, be_hit;
  logic [NP-1:0][SEL_W-1:0]     gs_src, be_src;

  tdm_slot_timer #(.SLOTS(SLOTS), .SLOT_LEN(SLOT_LEN)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_idx  (cur_slot),
    .round_end (round_end)
  );

  tdm_slot_table #(.SLOTS(SLOTS), .NP(NP), .EW(EW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_entry (cfg_entry),
    .round_end (round_end),
    .slot_idx  (cur_slot),
    .cur_entry (cur_entry)
  );

  for (genvar p = 0; p < NP; p++) begin : g_be
    tdm_be_fifo #(.W(W), .DEPTH(BE_DEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (be_in_valid[p]),
      .in_ready   (be_in_ready[p]),
      .in_data    (be_in_data[p]),
      .head_valid (be_head_vld[p]),
      .head_data  (be_head[p]),
      .pop        (be_pop[p])
    );
  end

  // One-flit GS holding register per input; a scheduled flit never waits.
  always_comb begin
    gs_vld_d = gs_in_valid;
    for (int p = 0; p < NP; p++) begin
      gs_dat_d[p] = gs_in_valid[p] ? gs_in_data[p] : gs_dat_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs_vld_q <= '0;
      gs_dat_q <= '0;
    end else begin
      gs_vld_q <= gs_vld_d;
      gs_dat_q <= gs_dat_d;
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      be_route[i] = SEL_W'(xy_route(
        int'(be_head[i][W-1 -: COORD_W]),
        int'(be_head[i][W-1-COORD_W -: COORD_W]),
        MY_X, MY_Y));
    end
  end

  // Crossbar: the table decides GS; free outputs go to BE by input order.
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      reserved[o] = cur_entry[o*ENTRY_W + SEL_W];
      gs_src[o]   = cur_entry[o*ENTRY_W +: SEL_W];
      gs_hit[o]   = 1'b0;
      be_hit[o]   = 1'b0;
      be_src[o]   = '0;
      for (int i = 0; i < NP; i++) begin
        if (reserved[o] && gs_src[o] == SEL_W'(i)) gs_hit[o] = gs_vld_q[i];
      end
      for (int i = NP - 1; i >= 0; i--) begin
        if (!reserved[o] && be_head_vld[i] && be_route[i] == SEL_W'(o)) begin
          be_hit[o] = 1'b1;
          be_src[o] = SEL_W'(i);
        end
      end
      out_valid[o] = gs_hit[o] || be_hit[o];
      out_gs[o]    = gs_hit[o];
      out_data[o]  = '0;
      for (int i = 0; i < NP; i++) begin
        if (gs_hit[o] && gs_src[o] == SEL_W'(i))      out_data[o] = gs_dat_q[i];
        else if (be_hit[o] && be_src[o] == SEL_W'(i)) out_data[o] = be_head[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      be_pop[i] = 1'b0;
      for (int o = 0; o < NP; o++) begin
        if (be_hit[o] && be_src[o] == SEL_W'(i) && out_ready[o]) be_pop[i] = 1'b1;
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_chk
    assert_be_not_on_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_gs[o]) |-> !cur_entry[o*ENTRY_W + SEL_W]);

    assert_gs_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && out_gs[o]) |-> $past(|gs_in_valid));
  end

endmodule

// File: tb/tdm_router_test.sv
module tdm_router_test;
  localparam int NP = 5;
  localparam int W  = 16;
  localparam int S  = 8;
  localparam int SL = 4;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 cfg_we;
  logic [2:0]           cfg_addr;
  logic [19:0]          cfg_entry;
  logic [NP-1:0]        gs_in_valid;
  logic [NP-1:0][W-1:0] gs_in_data;
  logic [NP-1:0]        be_in_valid;
  logic [NP-1:0]        be_in_ready;
  logic [NP-1:0][W-1:0] be_in_data;
  logic [NP-1:0]        out_valid;
  logic [NP-1:0]        out_gs;
  logic [NP-1:0][W-1:0] out_data;
  logic [NP-1:0]        out_ready;
  logic [2:0]           cur_slot;

  int checks = 0;
  int fails  = 0;
  int unsigned n = 0;
  bit done = 0;

  tdm_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_entry(cfg_entry), .gs_in_valid(gs_in_valid), .gs_in_data(gs_in_data),
    .be_in_valid(be_in_valid), .be_in_ready(be_in_ready), .be_in_data(be_in_data),
    .out_valid(out_valid), .out_gs(out_gs), .out_data(out_data),
    .out_ready(out_ready), .cur_slot(cur_slot)
  );

  always #4 clk = ~clk;

  // Rising edges since reset release; predicts the slot.
  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else        n <= n + 1;
  end

  function automatic int slot_of(int unsigned nn);
    return (nn / SL) % S;
  endfunction

  // Test schedule: slots 0..5 map input (s+1)%5 to output s%5,
  // slot 6 reserves output 1 with select 7, slot 7 is all free.
  function automatic logic [19:0] ent_of(int s);
    logic [19:0] e = '0;
    if (s <= 5) e[4*(s%5) +: 4] = {1'b1, 3'((s+1)%5)};
    if (s == 6) e[4 +: 4] = 4'b1111;
    return e;
  endfunction

  // {slot, input, expected output (7 = none)}
  localparam logic [8:0] VEC [9] = '{
    {3'd0, 3'd1, 3'd0}, {3'd1, 3'd2, 3'd1}, {3'd2, 3'd3, 3'd2},
    {3'd3, 3'd4, 3'd3}, {3'd4, 3'd0, 3'd4}, {3'd5, 3'd1, 3'd0},
    {3'd0, 3'd3, 3'd7}, {3'd6, 3'd2, 3'd7}, {3'd2, 3'd0, 3'd7}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Return at the falling edge just before the first rising edge of slot s.
  task automatic wait_pre(input int s);
    @(negedge clk);
    while (slot_of(n + 1) != s || ((n + 1) % SL) != 0) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] got [4];
    int cnt;
    rst_n = 1'b0; cfg_we = 0; cfg_addr = '0; cfg_entry = '0;
    gs_in_valid = '0; gs_in_data = '0; be_in_valid = '0; be_in_data = '0;
    out_ready = '1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "out_valid", 32'(out_valid), 0);
    chk("R10", "be_in_ready", 32'(be_in_ready), 32'h1f);
    chk("R10", "cur_slot", 32'(cur_slot), 0);
    rst_n = 1'b1;

    // Program the shadow table during round 0.
    for (int s = 0; s < S; s++) begin
      @(negedge clk);
      cfg_we = 1; cfg_addr = 3'(s); cfg_entry = ent_of(s);
    end
    @(negedge clk);
    cfg_we = 0;

    // R9: still round 0, active table empty -> GS flit goes nowhere.
    wait_pre(5);
    gs_in_valid[1] = 1; gs_in_data[1] = 16'h1234;
    @(negedge clk);
    gs_in_valid = '0;
    chk("R9", "out_valid before wrap", 32'(out_valid), 0);
    chk("R1", "cur_slot", 32'(cur_slot), 32'(slot_of(n)));

    // Vector table: R2/R3, with out_ready low throughout (R8: GS ignores it).
    out_ready = '0;
    for (int k = 0; k < 9; k++) begin
      int vs, vi, vo;
      vs = int'(VEC[k][8:6]); vi = int'(VEC[k][5:3]); vo = int'(VEC[k][2:0]);
      wait_pre(vs);
      gs_in_valid[vi] = 1; gs_in_data[vi] = 16'hA000 | 16'(k);
      @(negedge clk);
      gs_in_valid = '0;
      chk("R1", "cur_slot", 32'(cur_slot), 32'(vs));
      for (int o = 0; o < NP; o++) begin
        chk(vo == 7 ? "R3" : "R2", "out_valid", 32'(out_valid[o]), 32'(o == vo));
        if (o == vo) begin
          chk("R2", "out_gs", 32'(out_gs[o]), 1);
          chk("R8", "gs data with ready low", 32'(out_data[o]), 32'(16'hA000 | 16'(k)));
        end
      end
    end
    out_ready = '1;

    // R5: all five XY directions at once in free slot 7.
    wait_pre(7);
    be_in_valid = '1;
    be_in_data[0] = 16'h9011; be_in_data[1] = 16'h1022; be_in_data[2] = 16'h6033;
    be_in_data[3] = 16'h4044; be_in_data[4] = 16'h5055;
    @(negedge clk);
    be_in_valid = '0;
    chk("R5", "out_valid", 32'(out_valid), 32'h1f);
    chk("R5", "out_gs", 32'(out_gs), 0);
    chk("R5", "east", 32'(out_data[2]), 32'h9011);
    chk("R5", "west", 32'(out_data[4]), 32'h1022);
    chk("R5", "north", 32'(out_data[1]), 32'h6033);
    chk("R5", "south", 32'(out_data[3]), 32'h4044);
    chk("R5", "local", 32'(out_data[0]), 32'h5055);
    @(negedge clk);
    chk("R8", "popped with ready high", 32'(out_valid), 0);

    // R4: BE to local waits through slot 0 (output 0 reserved, no GS flit).
    wait_pre(0);
    be_in_valid[2] = 1; be_in_data[2] = 16'h5ABC;
    @(negedge clk);
    be_in_valid = '0;
    while (slot_of(n) == 0) begin
      chk("R4", "reserved out0 idle", 32'(out_valid[0]), 0);
      @(negedge clk);
    end
    chk("R4", "after slot end valid", 32'(out_valid[0]), 1);
    chk("R4", "after slot end data", 32'(out_data[0]), 32'h5ABC);
    @(negedge clk);

    // R4: select 7 in slot 6 still blocks BE on output 1.
    wait_pre(6);
    be_in_valid[0] = 1; be_in_data[0] = 16'h6DEF;
    @(negedge clk);
    be_in_valid = '0;
    chk("R4", "slot6 out1 idle", 32'(out_valid[1]), 0);
    while (slot_of(n) == 6) @(negedge clk);
    chk("R4", "slot7 out1 data", 32'(out_data[1]), 32'h6DEF);
    @(negedge clk);

    // R6: inputs 3 and 1 both to local; input 1 first.
    out_ready[0] = 0;
    be_in_valid[3] = 1; be_in_data[3] = 16'h5333;
    be_in_valid[1] = 1; be_in_data[1] = 16'h5111;
    @(negedge clk);
    be_in_valid = '0;
    wait_pre(7);
    out_ready[0] = 1;
    chk("R6", "first winner", 32'(out_data[0]), 32'h5111);
    @(negedge clk);
    chk("R6", "second", 32'(out_data[0]), 32'h5333);
    @(negedge clk);

    // R7/R8: fill input 0 toward east while out_ready[2] is low.
    out_ready[2] = 0;
    for (int k = 0; k < 5; k++) begin
      chk("R7", "ready before push", 32'(be_in_ready[0]), 32'(k < 4));
      be_in_valid[0] = 1; be_in_data[0] = 16'h9000 | 16'(k + 1);
      @(negedge clk);
    end
    be_in_valid = '0;
    repeat (6) @(negedge clk);
    chk("R7", "ready while full", 32'(be_in_ready[0]), 0);
    out_ready[2] = 1;
    cnt = 0;
    for (int t = 0; t < 40; t++) begin
      if (out_valid[2] && !out_gs[2]) begin
        if (cnt < 4) got[cnt] = out_data[2];
        cnt++;
      end
      @(negedge clk);
    end
    chk("R7", "drained count", 32'(cnt), 4);
    for (int k = 0; k < 4; k++)
      chk("R8", "held flit order", 32'(got[k]), 32'(16'h9000 | 16'(k + 1)));

    // R9: a write in mid-round lands only after the next wrap.
    wait_pre(3);
    cfg_we = 1; cfg_addr = 3'd7; cfg_entry = 20'h00800;
    @(negedge clk);
    cfg_we = 0;
    wait_pre(7);
    gs_in_valid[0] = 1; gs_in_data[0] = 16'hBEEF;
    @(negedge clk);
    gs_in_valid = '0;
    chk("R9", "same round", 32'(out_valid[2]), 0);
    wait_pre(7);
    gs_in_valid[0] = 1; gs_in_data[0] = 16'hCAFE;
    @(negedge clk);
    gs_in_valid = '0;
    chk("R9", "next round valid", 32'(out_valid[2] && out_gs[2]), 1);
    chk("R9", "next round data", 32'(out_data[2]), 32'hCAFE);
    chk("R1", "cur_slot", 32'(cur_slot), 32'(slot_of(n)));

    finish_run();
  end
endmodule